// File: doc/BRIEF.md
# Supply Dip Margining Sequencer

This block steps a core supply through a planned series of short undervoltage dips, so that a test setup can find the depth and duration at which the device under test starts to misbehave. It drives a digital code to an external supply-control converter. Between dips the code sits at a nominal value. During a dip the code is lowered by the current depth. The pulses follow a 1 kHz timebase, and each dip is followed by a recovery interval of the same length.

The sweep has two nested levels. The inner level steps the depth: 5 percent first, then 10 percent, then in 10 percent steps up to 50 percent. The outer level steps the dip duration: 5 ms first, then 10 ms, then in 10 ms steps up to 100 ms. A full depth sweep runs at every duration. The test controller pulses `advance` when the present setting has shown no effect, which moves to the next setting. It pulses `anomaly` when the device misbehaved, which freezes the sweep so the failing setting can be read from the index outputs. `done` reports that the deepest, longest dip was reached and passed without incident.

Top module: `dip_margin_seq`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and directly after it, `dac_code` equals NOMINAL, `depth_idx` and `width_idx` are 0, `done` is 0, and the sequencer is idle until `start`.
- R2: Depth index k selects a dip of p percent, with p = 5 for k = 0 and p = 10*k for k = 1..5. While dipping, `dac_code` = floor(NOMINAL*(100-p)/100). With NOMINAL = 1000 this gives 950, 900, 800, 700, 600, 500.
- R3: Width index j selects a dip duration of 5 ticks for j = 0 and 10*j ticks for j = 1..10, so the longest dip is 100 ticks.
- R4: After `start` or `advance`, the code stays at NOMINAL until the next clock with `tick` high. After that edge the code is dipped. It returns to NOMINAL on the W-th later tick, with W the current duration. It stays at NOMINAL for W ticks and dips again at the W-th tick of the gap. Without `tick` the code does not change.
- R5: `advance` during a sweep increments the depth index. At depth index 5 it resets the depth index to 0 and increments the width index. Either way the code goes to NOMINAL on the next clock and the R4 wait for a tick starts again.
- R6: `anomaly` during a sweep freezes it. From the next clock the code is NOMINAL and the indices hold. `advance` and `tick` then have no effect until `start`. `anomaly` wins over a simultaneous `advance`.
- R7: `advance` at depth index 5 and width index 10 sets `done`. The code stays NOMINAL and the indices hold at 5 and 10. Further `advance` and `tick` change nothing.
- R8: `start` when idle, frozen or done restarts the sweep at indices 0,0 and clears `done`. `start` during a sweep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart a sweep |
| advance | input | 1 | No effect seen: move to the next setting |
| anomaly | input | 1 | Device misbehaved: freeze the sweep |
| tick | input | 1 | One-cycle strobe at 1 kHz |
| dac_code | output | CODE_W (10) | Code to the supply-control converter |
| depth_idx | output | DI_W = clog2(N_DEPTH) (3) | Current depth index |
| width_idx | output | WI_W = clog2(N_WIDTH) (4) | Current duration index |
| done | output | 1 | Whole sweep passed without anomaly |

## Verification
The bench measures the dip and recovery lengths in ticks at every duration, from the 5-tick first step to the 100-tick last one. A counter that is off by one would show as a dip or gap one tick too long or too short. The uneven first depth step is checked against 950 then 900. A table with a plain 10 percent step would give 900 at index 0. The bench also checks the wrap from depth 50 percent to the next duration. A stepper that skips the wrap would leave the width index unchanged. Other corners covered are `anomaly` together with `advance`, `advance` ignored while frozen, `start` ignored during a sweep, and `advance` and `tick` after `done`. A design that lets the wrong input win would show a moved index or a dipped code where NOMINAL is required.

// File: rtl/dipseq_pkg.sv
package dipseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_DIP,
        ST_GAP,
        ST_HALT,
        ST_DONE
    } seq_state_e;

    // Dip depth in percent for a depth index: uneven first step.
    function automatic int unsigned depth_pct(input int unsigned idx);
        return (idx == 0) ? 5 : 10 * idx;
    endfunction

    // Dip duration in ticks for a width index: uneven first step.
    function automatic int unsigned width_ticks(input int unsigned idx);
        return (idx == 0) ? 5 : 10 * idx;
    endfunction

endpackage

// File: rtl/dip_code_rom.sv
module dip_code_rom
    import dipseq_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int NOMINAL = 1000,
    parameter int N_DEPTH = 6,
    parameter int DI_W    = 3
) (
    input  logic [DI_W-1:0]   depth_idx,
    output logic [CODE_W-1:0] dip_code
);
    localparam int ENTRIES = 2 ** DI_W;

    logic [CODE_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        if (g < N_DEPTH) begin : g_used
            assign tbl[g] = CODE_W'((NOMINAL * (100 - int'(depth_pct(g)))) / 100);
        end else begin : g_spare
            assign tbl[g] = CODE_W'(NOMINAL);
        end
    end

    assign dip_code = tbl[depth_idx];
endmodule

// File: rtl/dip_width_rom.sv
module dip_width_rom
    import dipseq_pkg::*;
#(
    parameter int N_WIDTH = 11,
    parameter int WI_W    = 4,
    parameter int CNT_W   = 7
) (
    input  logic [WI_W-1:0]  width_idx,
    output logic [CNT_W-1:0] last_cnt
);
    localparam int ENTRIES = 2 ** WI_W;

    logic [CNT_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        if (g < N_WIDTH) begin : g_used
            assign tbl[g] = CNT_W'(width_ticks(g) - 1);
        end else begin : g_spare
            assign tbl[g] = '0;
        end
    end

    assign last_cnt = tbl[width_idx];
endmodule

// File: rtl/dip_sweep_step.sv
module dip_sweep_step #(
    parameter int N_DEPTH = 6,
    parameter int N_WIDTH = 11,
    parameter int DI_W    = 3,
    parameter int WI_W    = 4
) (
    input  logic [DI_W-1:0] depth_idx,
    input  logic [WI_W-1:0] width_idx,
    output logic [DI_W-1:0] nxt_depth,
    output logic [WI_W-1:0] nxt_width,
    output logic            at_end
);
    logic depth_last;
    logic width_last;

    assign depth_last = (depth_idx == DI_W'(N_DEPTH - 1));
    assign width_last = (width_idx == WI_W'(N_WIDTH - 1));
    assign at_end     = depth_last && width_last;

    always_comb begin
        if (depth_last) begin
            nxt_depth = '0;
            nxt_width = width_idx + 1'b1;
        end else begin
            nxt_depth = depth_idx + 1'b1;
            nxt_width = width_idx;
        end
    end
endmodule

// File: rtl/dip_margin_seq.sv
module dip_margin_seq
    import dipseq_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int NOMINAL   = 1000,
    parameter int N_DEPTH   = 6,
    parameter int N_WIDTH   = 11,
    localparam int DI_W     = (N_DEPTH > 1) ? $clog2(N_DEPTH) : 1,
    localparam int WI_W     = (N_WIDTH > 1) ? $clog2(N_WIDTH) : 1,
    localparam int MAX_TICK = int'(width_ticks(N_WIDTH - 1)),
    localparam int CNT_W    = (MAX_TICK > 1) ? $clog2(MAX_TICK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic              anomaly,
    input  logic              tick,
    output logic [CODE_W-1:0] dac_code,
    output logic [DI_W-1:0]   depth_idx,
    output logic [WI_W-1:0]   width_idx,
    output logic              done
);
    typedef struct packed {
        seq_state_e        st;
        logic [DI_W-1:0]   depth;
        logic [WI_W-1:0]   width;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st:    ST_IDLE,
        depth: '0,
        width: '0,
        cnt:   '0,
        code:  CODE_W'(NOMINAL)
    };

    regs_t r_q, r_d;

    logic [CODE_W-1:0] dip_code;
    logic [CNT_W-1:0]  last_cnt;
    logic [DI_W-1:0]   nxt_depth;
    logic [WI_W-1:0]   nxt_width;
    logic              at_end;
    logic              sweeping;

    dip_code_rom #(
        .CODE_W (CODE_W),
        .NOMINAL(NOMINAL),
        .N_DEPTH(N_DEPTH),
        .DI_W   (DI_W)
    ) u_code (
        .depth_idx(r_q.depth),
        .dip_code (dip_code)
    );

    dip_width_rom #(
        .N_WIDTH(N_WIDTH),
        .WI_W   (WI_W),
        .CNT_W  (CNT_W)
    ) u_width (
        .width_idx(r_q.width),
        .last_cnt (last_cnt)
    );

    dip_sweep_step #(
        .N_DEPTH(N_DEPTH),
        .N_WIDTH(N_WIDTH),
        .DI_W   (DI_W),
        .WI_W   (WI_W)
    ) u_step (
        .depth_idx(r_q.depth),
        .width_idx(r_q.width),
        .nxt_depth(nxt_depth),
        .nxt_width(nxt_width),
        .at_end   (at_end)
    );

    assign sweeping = (r_q.st == ST_ARM) || (r_q.st == ST_DIP) || (r_q.st == ST_GAP);

    always_comb begin
        r_d = r_q;

        unique case (r_q.st)
            ST_IDLE, ST_HALT, ST_DONE: begin
                if (start) begin
                    r_d.st    = ST_ARM;
                    r_d.depth = '0;
                    r_d.width = '0;
                    r_d.cnt   = '0;
                end
            end
            ST_ARM: begin
                if (tick) begin
                    r_d.st  = ST_DIP;
                    r_d.cnt = '0;
                end
            end
            ST_DIP: begin
                if (tick) begin
                    if (r_q.cnt == last_cnt) begin
                        r_d.st  = ST_GAP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.cnt == last_cnt) begin
                        r_d.st  = ST_DIP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d = RESET_VAL;
        endcase

        // Sweep control overrides the pulse timing.
        if (sweeping) begin
            if (anomaly) begin
                r_d.st  = ST_HALT;
                r_d.cnt = '0;
            end else if (advance) begin
                r_d.cnt = '0;
                if (at_end) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.st    = ST_ARM;
                    r_d.depth = nxt_depth;
                    r_d.width = nxt_width;
                end
            end
        end

        // Depth never changes on entry to a dip, so the current depth code applies.
        r_d.code = (r_d.st == ST_DIP) ? dip_code : CODE_W'(NOMINAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_code  = r_q.code;
    assign depth_idx = r_q.depth;
    assign width_idx = r_q.width;
    assign done      = (r_q.st == ST_DONE);
endmodule

// File: rtl/dip_margin_seq_chk.sv
module dip_margin_seq_chk #(
    parameter int CODE_W  = 10,
    parameter int NOMINAL = 1000,
    parameter int N_DEPTH = 6,
    parameter int N_WIDTH = 11,
    parameter int DI_W    = 3,
    parameter int WI_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              advance,
    input logic              anomaly,
    input logic              tick,
    input logic [CODE_W-1:0] dac_code,
    input logic [DI_W-1:0]   depth_idx,
    input logic [WI_W-1:0]   width_idx,
    input logic              done
);
    assert_depth_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth_idx) < N_DEPTH);

    assert_width_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(width_idx) < N_WIDTH);

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !advance && !anomaly && !start) |=> $stable(dac_code));

    assert_index_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !start) |=> ($stable(depth_idx) && $stable(width_idx)));

    assert_advance_nominal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start) |=> (dac_code == CODE_W'(NOMINAL)));

    assert_anomaly_nominal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (anomaly && !start) |=> (dac_code == CODE_W'(NOMINAL)));

    assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (int'(depth_idx) == N_DEPTH - 1 && int'(width_idx) == N_WIDTH - 1));

    assert_done_nominal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dac_code == CODE_W'(NOMINAL)));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && depth_idx == '0 && width_idx == '0));
endmodule

bind dip_margin_seq dip_margin_seq_chk #(
    .CODE_W (CODE_W),
    .NOMINAL(NOMINAL),
    .N_DEPTH(N_DEPTH),
    .N_WIDTH(N_WIDTH),
    .DI_W   (DI_W),
    .WI_W   (WI_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .advance  (advance),
    .anomaly  (anomaly),
    .tick     (tick),
    .dac_code (dac_code),
    .depth_idx(depth_idx),
    .width_idx(width_idx),
    .done     (done)
);

// File: tb/sim_dip_margin_seq.sv
module sim_dip_margin_seq;
    localparam int NOM = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       advance = 1'b0;
    logic       anomaly = 1'b0;
    logic       tick = 1'b0;
    logic [9:0] dac_code;
    logic [2:0] depth_idx;
    logic [3:0] width_idx;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dip_margin_seq u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .advance  (advance),
        .anomaly  (anomaly),
        .tick     (tick),
        .dac_code (dac_code),
        .depth_idx(depth_idx),
        .width_idx(width_idx),
        .done     (done)
    );

    function automatic int exp_code(input int d);
        int p;
        p = (d == 0) ? 5 : 10 * d;
        return (NOM * (100 - p)) / 100;
    endfunction

    function automatic int exp_width(input int w);
        return (w == 0) ? 5 : 10 * w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic a, input logic x, input logic t);
        start   = s;
        advance = a;
        anomaly = x;
        tick    = t;
        @(posedge clk);
        #1;
        start   = 1'b0;
        advance = 1'b0;
        anomaly = 1'b0;
        tick    = 1'b0;
    endtask

    // {start, advance, anomaly, tick, code[9:0], depth[2:0], width[3:0], done}
    localparam int NV = 22;
    localparam logic [21:0] VEC [NV] = '{
        {4'b1000, 10'd1000, 3'd0, 4'd0, 1'b0},  // R8 start from idle
        {4'b0000, 10'd1000, 3'd0, 4'd0, 1'b0},  // R4 waits for tick
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0},  // R2 R4 dip begins
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0},
        {4'b0000, 10'd950,  3'd0, 4'd0, 1'b0},  // R4 no tick, hold
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd1000, 3'd0, 4'd0, 1'b0},  // R4 fifth tick ends dip
        {4'b1000, 10'd1000, 3'd0, 4'd0, 1'b0},  // R8 start ignored in sweep
        {4'b0001, 10'd1000, 3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd1000, 3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd1000, 3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd1000, 3'd0, 4'd0, 1'b0},
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0},  // R4 fifth gap tick redips
        {4'b0100, 10'd1000, 3'd1, 4'd0, 1'b0},  // R5 advance depth
        {4'b0001, 10'd900,  3'd1, 4'd0, 1'b0},  // R2 second depth 10 percent
        {4'b0110, 10'd1000, 3'd1, 4'd0, 1'b0},  // R6 anomaly beats advance
        {4'b0100, 10'd1000, 3'd1, 4'd0, 1'b0},  // R6 advance ignored frozen
        {4'b0001, 10'd1000, 3'd1, 4'd0, 1'b0},  // R6 tick ignored frozen
        {4'b1000, 10'd1000, 3'd0, 4'd0, 1'b0},  // R8 restart from frozen
        {4'b0001, 10'd950,  3'd0, 4'd0, 1'b0}   // R2 dip after restart
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int cnt;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 code in reset", int'(dac_code), NOM);
        check("R1 depth in reset", int'(depth_idx), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R1 idle ignores tick code", int'(dac_code), NOM);
        check("R1 done after reset", int'(done), 0);
        check("R1 width after reset", int'(width_idx), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18]);
            check($sformatf("R4 row %0d code", i), int'(dac_code), int'(VEC[i][17:8]));
            check($sformatf("R5 row %0d depth", i), int'(depth_idx), int'(VEC[i][7:5]));
            check($sformatf("R3 row %0d width", i), int'(width_idx), int'(VEC[i][4:1]));
            check($sformatf("R7 row %0d done", i), int'(done), int'(VEC[i][0]));
        end

        // R1 asynchronous reset in the middle of a dip
        rst_n = 1'b0;
        #1;
        check("R1 async reset code", int'(dac_code), NOM);
        check("R1 async reset depth", int'(depth_idx), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // Full sweep
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int w = 0; w < 11; w++) begin
            for (int d = 0; d < 6; d++) begin
                step(1'b0, 1'b0, 1'b0, 1'b1);
                check($sformatf("R2 code d%0d w%0d", d, w), int'(dac_code), exp_code(d));
                check($sformatf("R5 depth d%0d w%0d", d, w), int'(depth_idx), d);
                check($sformatf("R3 width d%0d w%0d", d, w), int'(width_idx), w);
                if (d == 0) begin
                    cnt = 0;
                    while (int'(dac_code) != NOM && cnt < 200) begin
                        step(1'b0, 1'b0, 1'b0, 1'b1);
                        cnt++;
                    end
                    check($sformatf("R3 dip length w%0d", w), cnt, exp_width(w));
                    cnt = 0;
                    while (int'(dac_code) == NOM && cnt < 200) begin
                        step(1'b0, 1'b0, 1'b0, 1'b1);
                        cnt++;
                    end
                    check($sformatf("R4 gap length w%0d", w), cnt, exp_width(w));
                end
                step(1'b0, 1'b1, 1'b0, 1'b0);
                check($sformatf("R5 nominal after advance d%0d w%0d", d, w), int'(dac_code), NOM);
            end
        end
        check("R7 done at end", int'(done), 1);
        check("R7 depth held", int'(depth_idx), 5);
        check("R7 width held", int'(width_idx), 10);

        step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R7 advance ignored when done", int'(done), 1);
        check("R7 code nominal when done", int'(dac_code), NOM);
        check("R7 depth unchanged when done", int'(depth_idx), 5);

        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 start clears done", int'(done), 0);
        check("R8 start resets width", int'(width_idx), 0);
        check("R8 start resets depth", int'(depth_idx), 0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 first dip after restart", int'(dac_code), exp_code(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule